// File: doc/BRIEF.md
# SPI Register Slave with SCLK Idle Watchdog

This block is a serial register port for a chip that runs on a fast master clock. The external controller drives chip select, serial clock and serial data in. The block samples all three through synchronisers in the master clock domain and finds SCLK edges from those samples. It receives a command byte and then either returns one register on DOUT or loads one register from the next byte. The register file is small and made of flops. Its full contents are brought out in parallel, so that neighbouring logic can use the settings.

A watchdog counts master clocks while SCLK stays at one level with chip select active. If SCLK goes too long without an edge, the block drops whatever it has partly received and waits for a new command. It does not signal this in any other way. Bit 4 of register 0 selects the watchdog limit. When the bit is clear the limit is long. When it is set the limit is short, for systems that want a stuck clock line to recover quickly. SCLK must have a period of at least two master clocks. In practice each level should be held for several master clocks so that the synchronisers see it.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, register 0 holds 0x0A and every other register holds 0x00. DOUT and its output enable are low.
- R2: A transfer starts with a command byte, sent MSB first. Bits [7:5] are the opcode: 010 is a read and 011 is a write. Bits [3:0] give the register address. Bit 4 is ignored.
- R3: After a read command, the addressed register goes out on DOUT during the second byte, MSB first. Each bit is updated after a falling SCLK edge and holds until the next falling edge. The master samples bit 7 at the ninth falling edge of the transfer and bit 0 at the sixteenth.
- R4: After a write command, the second byte is captured MSB first on rising SCLK edges. It is stored in the addressed register after the sixteenth rising edge and appears on `reg_q`, where register n is bits [8n+7:8n].
- R5: Registers 0 to 3 exist. A write to any address from 4 to 15 changes nothing, and a read of such an address returns 0x00.
- R6: Opcodes other than 010 and 011 change no register, and DOUT stays 0 through the second byte.
- R7: While chip select is high, the output enable and DOUT are low. Raising chip select before the sixteenth rising edge abandons the transfer with no register change. The next transfer starts with a fresh command.
- R8: With chip select low and register 0 bit 4 clear, SCLK may stay at one level for more than 4096 master clocks. When it does, the partial transfer is discarded, and the next rising edge is taken as bit 7 of a new command. Shorter holds, at either level, leave the transfer intact.
- R9: With register 0 bit 4 set, the limit in R8 is 256 master clocks.
- R10: Rising edges after the sixteenth, within the same chip select period, are ignored. There is no further write, and DOUT stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the master, idles low |
| din | input | 1 | Serial data into the block |
| dout | output | 1 | Serial data out of the block |
| dout_oe | output | 1 | High while DOUT should be driven |
| reg_q | output | NUM_REGS*DATA_W (32) | Parallel register contents, register 0 in the low byte |

## Verification
The bench holds SCLK still for spans just under and well over each limit, both mid-command and mid-data, at high and at low level. A watchdog with an off-by-factor or a wrong limit select would either destroy valid slow transfers or let stale bits shift a later command out of alignment. In the failing case the misaligned bits are chosen so they decode as a harmless opcode. This means a missed reset shows up as a write that still lands. Sweeps cover every address and every opcode, with data patterns over all bit positions. They would catch an off-by-one DOUT phase (a shifted read value), a write landing on the wrong edge, and aliasing of unimplemented addresses onto real registers. Aborted and over-long transfers check that the bit counter is cleared by chip select and saturates after sixteen bits.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam logic [2:0] OPC_READ  = 3'b010;
  localparam logic [2:0] OPC_WRITE = 3'b011;

  function automatic op_e decode_op(input logic [2:0] field);
    case (field)
      OPC_READ:  return OP_READ;
      OPC_WRITE: return OP_WRITE;
      default:   return OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/spi_reg_sync.sv
// Brings CS, SCLK and DIN into the master clock domain and finds SCLK edges.
module spi_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic cs_act,
  output logic din_q,
  output logic sclk_rise,
  output logic sclk_fall
);

  // bit 2: cs_n, bit 1: sclk, bit 0: din
  localparam logic [2:0] IDLE_V = 3'b100;

  logic [2:0] stg [STAGES];
  logic       sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_V;
      sclk_prev <= 1'b0;
    end else begin
      stg[0] <= {cs_n, sclk, din};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_prev <= stg[STAGES-1][1];
    end
  end

  assign cs_act    = ~stg[STAGES-1][2];
  assign din_q     = stg[STAGES-1][0];
  assign sclk_rise = stg[STAGES-1][1] & ~sclk_prev;
  assign sclk_fall = ~stg[STAGES-1][1] & sclk_prev;

endmodule

// File: rtl/spi_reg_wdog.sv
// Counts master clocks since the last SCLK edge; fires when the limit is reached.
module spi_reg_wdog #(
  parameter int LONG_LIMIT  = 4096,
  parameter int SHORT_LIMIT = 256,
  localparam int CNT_W      = $clog2(LONG_LIMIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             sclk_edge,
  input  logic             short_sel,
  output logic             fire,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_LIMIT - 1);
  localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_LIMIT - 1);

  logic [CNT_W-1:0] limit_m1;

  assign limit_m1 = short_sel ? SHORT_M1 : LONG_M1;
  assign fire     = active && !sclk_edge && (cnt >= limit_m1);

  always_ff @(posedge clk) begin
    if (rst || !active || sclk_edge || fire) cnt <= '0;
    else                                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_reg_file.sv
// Flop-based register file with one write port and a parallel view.
module spi_reg_file #(
  parameter int              DATA_W     = 8,
  parameter int              ADDR_W     = 4,
  parameter int              NUM_REGS   = 4,
  parameter logic [DATA_W-1:0] REG0_RESET = 8'h0A
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V = (g == 0) ? REG0_RESET : '0;
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst)                                     q <= RST_V;
      else if (wr_en && wr_addr == ADDR_W'(g))     q <= wr_data;
    end

    assign regs_flat[g*DATA_W +: DATA_W] = q;
  end

  // Unimplemented addresses read as zero.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs_flat[i*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/spi_reg_slave.sv
// Serial register port: command byte, then one data byte in or out.
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 4,
  parameter int                NUM_REGS    = 4,
  parameter int                LONG_LIMIT  = 4096,
  parameter int                SHORT_LIMIT = 256,
  parameter int                SYNC_STAGES = 2,
  parameter int                SEL_BIT     = 4,
  parameter logic [DATA_W-1:0] REG0_RESET  = 8'h0A
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       din,
  output logic                       dout,
  output logic                       dout_oe,
  output logic [NUM_REGS*DATA_W-1:0] reg_q
);

  localparam int XFER_BITS = 2 * DATA_W;
  localparam int BC_W      = $clog2(XFER_BITS + 1);
  localparam int CNT_W     = $clog2(LONG_LIMIT);

  localparam logic [BC_W-1:0] BC_CMD_LAST  = BC_W'(DATA_W - 1);
  localparam logic [BC_W-1:0] BC_DATA_FST  = BC_W'(DATA_W);
  localparam logic [BC_W-1:0] BC_XFER_LAST = BC_W'(XFER_BITS - 1);
  localparam logic [BC_W-1:0] BC_DONE      = BC_W'(XFER_BITS);

  // synchronised inputs
  logic cs_act, din_q, sclk_rise, sclk_fall;

  // watchdog
  logic             wd_fire;
  logic [CNT_W-1:0] wd_cnt;
  logic             short_sel;

  // transfer state
  logic [BC_W-1:0]   bit_cnt;
  logic [DATA_W-2:0] cmd_sh;
  logic [DATA_W-2:0] wr_sh;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] cmd_next;
  logic [DATA_W-1:0] byte_next;
  op_e               op_q;
  op_e               op_dec;
  logic [ADDR_W-1:0] addr_q;
  logic              abort;

  // register file port
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  logic dout_q, oe_q;

  spi_reg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .din       (din),
    .cs_act    (cs_act),
    .din_q     (din_q),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  spi_reg_wdog #(.LONG_LIMIT(LONG_LIMIT), .SHORT_LIMIT(SHORT_LIMIT)) u_wdog (
    .clk       (clk),
    .rst       (rst),
    .active    (cs_act),
    .sclk_edge (sclk_rise | sclk_fall),
    .short_sel (short_sel),
    .fire      (wd_fire),
    .cnt       (wd_cnt)
  );

  spi_reg_file #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_REGS   (NUM_REGS),
    .REG0_RESET (REG0_RESET)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (addr_q),
    .wr_data   (wr_data),
    .rd_addr   (cmd_next[ADDR_W-1:0]),
    .rd_data   (rd_data),
    .regs_flat (reg_q)
  );

  assign short_sel = reg_q[SEL_BIT];
  assign abort     = !cs_act || wd_fire;
  assign cmd_next  = {cmd_sh, din_q};
  assign byte_next = {wr_sh, din_q};
  assign op_dec    = decode_op(cmd_next[DATA_W-1 -: 3]);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      bit_cnt <= '0;
      cmd_sh  <= '0;
      wr_sh   <= '0;
      tx_sh   <= '0;
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (sclk_rise && bit_cnt != BC_DONE) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < BC_DATA_FST) begin
          cmd_sh <= cmd_next[DATA_W-2:0];
          if (bit_cnt == BC_CMD_LAST) begin
            op_q   <= op_dec;
            addr_q <= cmd_next[ADDR_W-1:0];
            if (op_dec == OP_READ) tx_sh <= rd_data;
          end
        end else begin
          wr_sh <= byte_next[DATA_W-2:0];
          if (bit_cnt == BC_XFER_LAST && op_q == OP_WRITE) begin
            wr_en   <= 1'b1;
            wr_data <= byte_next;
          end
        end
      end
      if (sclk_fall) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) dout_q <= 1'b0;
    else if (sclk_fall) dout_q <= tx_sh[DATA_W-1];
    oe_q <= rst ? 1'b0 : cs_act;
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int                DATA_W      = 8,
  parameter int                NUM_REGS    = 4,
  parameter int                SHORT_LIMIT = 256,
  parameter int                XFER_BITS   = 16,
  parameter int                BC_W        = 5,
  parameter int                CNT_W       = 12,
  parameter logic [DATA_W-1:0] REG0_RESET  = 8'h0A
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       dout,
  input logic                       dout_oe,
  input logic [NUM_REGS*DATA_W-1:0] reg_q,
  input logic                       wr_en,
  input logic [BC_W-1:0]            bit_cnt,
  input logic [CNT_W-1:0]           wd_cnt,
  input logic                       wd_fire,
  input logic                       short_sel
);

  p_reset_val_r1: assert property (@(posedge clk)
    rst |=> (reg_q[DATA_W-1:0] == REG0_RESET));

  p_quiet_off_r7: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> (dout == 1'b0));

  p_write_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_q) |-> $past(wr_en));

  p_fire_clears_r8: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> (bit_cnt == '0 && wd_cnt == '0));

  p_short_cap_r9: assert property (@(posedge clk) disable iff (rst)
    short_sel |-> (wd_cnt < CNT_W'(SHORT_LIMIT)));

  p_bitcnt_cap_r10: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BC_W'(XFER_BITS));

endmodule

bind spi_reg_slave spi_reg_slave_chk #(
  .DATA_W      (DATA_W),
  .NUM_REGS    (NUM_REGS),
  .SHORT_LIMIT (SHORT_LIMIT),
  .XFER_BITS   (XFER_BITS),
  .BC_W        (BC_W),
  .CNT_W       (CNT_W),
  .REG0_RESET  (REG0_RESET)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .reg_q     (reg_q),
  .wr_en     (wr_en),
  .bit_cnt   (bit_cnt),
  .wd_cnt    (wd_cnt),
  .wd_fire   (wd_fire),
  .short_sel (short_sel)
);

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;

  localparam int H = 6;  // SCLK half period in master clocks

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic        dout, dout_oe;
  logic [31:0] reg_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [7:0] model [16];

  always #10 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .reg_q(reg_q)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One chip-select period. stall_at < 0 means no stall.
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] data, input int nbits,
                      input int stall_at, input int stall_len, input bit stall_hi,
                      output logic [7:0] rd);
    rd = '0;
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 8) ? cmd[7-i] : ((i < 16) ? data[15-i] : 1'b1);
      if (i >= 9 && i <= 16) rd = {rd[6:0], dout};
      if (i == 4) check("R7 oe during transfer", {31'd0, dout_oe}, 32'd1);
      sclk = 1'b0; din = b;
      tick(H);
      if (i == stall_at && !stall_hi) tick(stall_len);
      sclk = 1'b1;
      tick(H);
      if (i == stall_at && stall_hi) tick(stall_len);
    end
    if (nbits == 16) rd = {rd[6:0], dout};
    if (nbits > 16) check("R10 dout quiet after data byte", {31'd0, dout}, 32'd0);
    sclk = 1'b0;
    tick(H);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    logic [7:0] rd;
    xfer({4'b0110, a}, v, 16, -1, 0, 1'b0, rd);
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    xfer({4'b0100, a}, 8'h00, 16, -1, 0, 1'b0, v);
  endtask

  function automatic logic [31:0] model_flat();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    model[0] = 8'h0A;

    tick(5);
    rst = 1'b0;
    tick(3);
    // R1 reset state
    check("R1 reg0 reset", {24'd0, reg_q[7:0]}, 32'h0A);
    check("R1 other regs reset", {8'd0, reg_q[31:8]}, 32'h0);
    check("R1 oe low", {31'd0, dout_oe}, 32'd0);
    check("R1 dout low", {31'd0, dout}, 32'd0);

    // R3 read of register 0
    rd_reg(4'd0, v);
    check("R3 read reg0", {24'd0, v}, 32'h0A);

    // R4 write sweep over implemented non-config registers
    for (int a = 1; a < 4; a++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] pat;
        pat = 8'((a * 37 + k * 53) ^ (1 << k));
        wr(4'(a), pat);
        model[a] = pat;
        check("R4 reg_q after write", reg_q, model_flat());
        rd_reg(4'(a), v);
        check("R3 readback", {24'd0, v}, {24'd0, pat});
      end
    end

    // R2 bit 4 of the command is ignored
    xfer(8'h72, 8'hC6, 16, -1, 0, 1'b0, v);
    model[2] = 8'hC6;
    check("R2 write with bit4 set", reg_q, model_flat());
    xfer(8'h52, 8'h00, 16, -1, 0, 1'b0, v);
    check("R2 read with bit4 set", {24'd0, v}, 32'hC6);

    // R5 unimplemented addresses
    for (int a = 4; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      check("R5 write to unimplemented dropped", reg_q, model_flat());
    end
    for (int a = 0; a < 16; a++) begin
      rd_reg(4'(a), v);
      check("R5 address sweep read", {24'd0, v}, {24'd0, model[a]});
    end

    // R6 other opcodes
    for (int op = 0; op < 8; op++) begin
      if (op == 2 || op == 3) continue;
      xfer({3'(op), 5'b00001}, 8'hFF, 16, -1, 0, 1'b0, v);
      check("R6 ignored opcode dout", {24'd0, v}, 32'h0);
      check("R6 ignored opcode regs", reg_q, model_flat());
    end

    // R7 early chip-select release
    xfer(8'h63, 8'h99, 12, -1, 0, 1'b0, v);
    check("R7 aborted write", reg_q, model_flat());
    wr(4'd3, 8'h3C);
    model[3] = 8'h3C;
    check("R7 next transfer fresh", reg_q, model_flat());

    // R10 extra clocks after sixteenth
    xfer(8'h61, 8'h24, 24, -1, 0, 1'b0, v);
    model[1] = 8'h24;
    check("R10 extra bits ignored", reg_q, model_flat());

    // R8 long limit
    xfer(8'h61, 8'h5A, 16, 3, 4200, 1'b1, v);
    check("R8 long stall high resets", reg_q, model_flat());
    xfer(8'h61, 8'h5A, 16, 3, 3900, 1'b1, v);
    model[1] = 8'h5A;
    check("R8 long stall under limit", reg_q, model_flat());
    xfer(8'h62, 8'hC3, 16, 10, 4200, 1'b0, v);
    check("R8 long stall low resets", reg_q, model_flat());
    xfer(8'h62, 8'hC3, 16, 10, 3900, 1'b0, v);
    model[2] = 8'hC3;
    check("R8 low stall under limit", reg_q, model_flat());
    xfer(8'h61, 8'h11, 16, 3, 300, 1'b1, v);
    model[1] = 8'h11;
    check("R8 300 clocks fine in long mode", reg_q, model_flat());

    // R9 short limit
    wr(4'd0, 8'h1A);
    model[0] = 8'h1A;
    check("R9 select bit set", reg_q, model_flat());
    xfer(8'h61, 8'h5A, 16, 3, 300, 1'b1, v);
    check("R9 short stall resets", reg_q, model_flat());
    xfer(8'h61, 8'h5A, 16, 3, 200, 1'b1, v);
    model[1] = 8'h5A;
    check("R9 short stall under limit", reg_q, model_flat());
    xfer(8'h62, 8'hC3 ^ 8'hFF, 16, 10, 300, 1'b0, v);
    check("R9 short low stall resets", reg_q, model_flat());
    rd_reg(4'd0, v);
    check("R9 config readback", {24'd0, v}, 32'h1A);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule